// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Controller

This block moves data between I/O devices and memory on behalf of the host processor, without the data ever passing through it. It has four channels. Each channel holds a current address, a current count, a direction bit and a mask bit. A device asks for service by raising its request line. The controller then asks the processor for the bus with a hold request and waits for the hold acknowledge. It then runs a single transfer cycle. In that cycle it drives the channel's address, pulls the channel's acknowledge low, and asserts an I/O strobe together with the opposite memory strobe, so the device and the memory exchange the data directly.

Only one channel runs at a time, and each grant covers exactly one transfer. After every transfer the bus is handed back. The controller only competes for the bus again once the processor has withdrawn its acknowledge. When a channel's count passes from zero to all ones, the end-of-process strobe pulses during that last transfer and the channel masks itself.

Software programs the channels through a plain synchronous byte-wide write port. A 16-bit system can use the same block unchanged: the board wiring shifts the address by one bit, so each transfer moves an even-aligned byte pair.

Data handshake: the controller carries no data stream, so it has no valid/ready interface. Back-pressure is expressed by the device keeping its request line high or dropping it, and by the processor holding off its acknowledge. The controller waits on either without limit.

Top module: `flyby_dma4`

## Requirements
- R1: After reset, hrq is low, every dack_n bit is high, all four strobes and eop_n are high, addr is 0, and all four channels are masked.
- R2: In the idle state, an unmasked request raises hrq one clock edge later. A request on a masked channel never raises hrq.
- R3: While hlda is low, the block holds every dack_n bit high and all four strobes high, even though hrq is high.
- R4: The channel is chosen at the edge where hlda is first seen high, using fixed priority: channel 0 is highest and channel 3 is lowest. A request that arrives before that edge competes; the choice never changes during a transfer.
- R5: Direction bit 0 (device to memory) pulls ior_n and memw_n low together in the transfer cycle. Direction bit 1 (memory to device) pulls memr_n and iow_n low together. The other two strobes stay high.
- R6: A transfer lasts exactly one cycle. In that cycle exactly one dack_n bit is low (bit n for channel n), and addr equals that channel's current address.
- R7: Each transfer increments the channel's 16-bit current address (wrapping from FFFF to 0000) and decrements its 16-bit count.
- R8: eop_n is low only during the transfer cycle in which the count is 0. The count then wraps to FFFF, the channel masks itself, and its request is ignored until software unmasks it.
- R9: hrq drops in the cycle after each transfer. hrq stays low until hlda has been seen low again.
- R10: A write with cfg_we high updates the channel selected by cfg_chan. cfg_sel selects the register: 0 = current address, 1 = current count, 2 = control. For address and count, cfg_hi selects the byte: 0 = bits 7:0, 1 = bits 15:8. For control, cfg_data bit 0 is the direction and bit 1 is the mask. If a write and a transfer on the same channel fall in the same cycle, the transfer update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_chan | input | 2 | Channel selected for the write |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_hi | input | 1 | Byte select: 0 low byte, 1 high byte |
| cfg_data | input | 8 | Write data |
| dreq | input | 4 | Per-channel service request from the devices |
| hlda | input | 1 | Hold acknowledge from the processor |
| hrq | output | 1 | Hold request to the processor |
| dack_n | output | 4 | Per-channel acknowledge, active low |
| addr | output | 16 | Memory address during a transfer, 0 otherwise |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| eop_n | output | 1 | End-of-process pulse, active low |

## Verification
A table of requests drives single requests, then several requests at once, with channels of both directions. The table tells fixed priority apart from first-come order, because a lower-numbered request that is raised later still wins the next grant. Address wrap, count wrap and terminal count are run on channels whose start values sit next to FFFF or zero, so an off-by-one in the end-of-process cycle shows up in the cycle where eop_n falls. Directed runs hold hlda off, request a channel that has masked itself, and write individual bytes. These runs separate a correct hold handshake and auto-mask from a block that drives the bus early or keeps serving a finished channel.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_MOVE,
    ST_FREE
  } seq_state_e;

  localparam logic [1:0] REG_ADDR = 2'd0;
  localparam logic [1:0] REG_CNT  = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import flyby_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic          wr_hi,
  input  logic [7:0]    wr_data,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic          cnt_zero,
  output logic          dir_m2d,
  output logic          masked
);
  logic [AW-1:0] addr_q, addr_wr;
  logic [CW-1:0] cnt_q, cnt_wr;
  logic          dir_q, mask_q;

  // byte merge for software writes
  always_comb begin
    addr_wr = addr_q;
    for (int i = 0; i < AW; i++) begin
      if ((i / 8) == int'(wr_hi)) addr_wr[i] = wr_data[i % 8];
    end
    cnt_wr = cnt_q;
    for (int i = 0; i < CW; i++) begin
      if ((i / 8) == int'(wr_hi)) cnt_wr[i] = wr_data[i % 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      mask_q <= 1'b1;
    end else if (step) begin
      addr_q <= addr_q + 1'b1;
      cnt_q  <= cnt_q - 1'b1;
      if (cnt_q == '0) mask_q <= 1'b1;
    end else if (wr_en) begin
      unique case (wr_sel)
        REG_ADDR: addr_q <= addr_wr;
        REG_CNT:  cnt_q  <= cnt_wr;
        REG_CTRL: begin
          dir_q  <= wr_data[0];
          mask_q <= wr_data[1];
        end
        default: ;
      endcase
    end
  end

  assign cur_addr = addr_q;
  assign cnt_zero = (cnt_q == '0);
  assign dir_m2d  = dir_q;
  assign masked   = mask_q;

  // R7: address advances by one per transfer
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cur_addr == AW'($past(cur_addr) + 1'b1));

  // R8: terminal transfer leaves the channel masked and count wrapped
  p_eop_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_zero) |=> (masked && !cnt_zero));
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic           hit,
  output logic [CHW-1:0] idx
);
  // lowest index wins: scan from the top so lower indices overwrite
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = CHW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import flyby_dma_pkg::*;
#(
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any_req,
  input  logic           hlda,
  input  logic           win_hit,
  input  logic [CHW-1:0] win_idx,
  output logic           hrq,
  output logic           move,
  output logic [CHW-1:0] act_idx
);
  seq_state_e state_q;
  logic [CHW-1:0] act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (any_req) state_q <= ST_HOLD;
        ST_HOLD: if (hlda) begin
          if (win_hit) begin
            state_q <= ST_MOVE;
            act_q   <= win_idx;
          end else begin
            state_q <= ST_FREE;
          end
        end
        ST_MOVE: state_q <= ST_FREE;
        ST_FREE: if (!hlda) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign hrq     = (state_q == ST_HOLD) || (state_q == ST_MOVE);
  assign move    = (state_q == ST_MOVE);
  assign act_idx = act_q;

  // R3: a transfer only follows an observed hold acknowledge
  p_move_after_hlda_r3: assert property (@(posedge clk) disable iff (!rst_n)
    move |-> $past(hlda));

  // R9: bus released after each transfer
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    move |=> !hrq);

  // R9: no new request while the processor still holds acknowledge
  p_wait_hlda_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FREE && hlda) |=> !hrq);
endmodule

// File: rtl/flyby_dma4.sv
module flyby_dma4 #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_chan,
  input  logic [1:0]     cfg_sel,
  input  logic           cfg_hi,
  input  logic [7:0]     cfg_data,
  input  logic [NCH-1:0] dreq,
  input  logic           hlda,
  output logic           hrq,
  output logic [NCH-1:0] dack_n,
  output logic [AW-1:0]  addr,
  output logic           memr_n,
  output logic           memw_n,
  output logic           ior_n,
  output logic           iow_n,
  output logic           eop_n
);
  logic [AW-1:0]  ch_addr [NCH];
  logic [NCH-1:0] ch_zero, ch_dir, ch_mask, eff_req;
  logic           win_hit, move;
  logic [CHW-1:0] win_idx, act_idx;
  logic           act_dir;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && (cfg_chan == CHW'(g))),
      .wr_sel   (cfg_sel),
      .wr_hi    (cfg_hi),
      .wr_data  (cfg_data),
      .step     (move && (act_idx == CHW'(g))),
      .cur_addr (ch_addr[g]),
      .cnt_zero (ch_zero[g]),
      .dir_m2d  (ch_dir[g]),
      .masked   (ch_mask[g])
    );
  end

  assign eff_req = dreq & ~ch_mask;

  dma_prio_arb #(.NCH(NCH)) u_arb (
    .req (eff_req),
    .hit (win_hit),
    .idx (win_idx)
  );

  dma_bus_seq #(.CHW(CHW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_req (|eff_req),
    .hlda    (hlda),
    .win_hit (win_hit),
    .win_idx (win_idx),
    .hrq     (hrq),
    .move    (move),
    .act_idx (act_idx)
  );

  assign act_dir = ch_dir[act_idx];
  assign dack_n  = move ? ~(NCH'(1) << act_idx) : '1;
  assign addr    = move ? ch_addr[act_idx] : '0;
  assign ior_n   = !(move && !act_dir);
  assign memw_n  = !(move && !act_dir);
  assign memr_n  = !(move && act_dir);
  assign iow_n   = !(move && act_dir);
  assign eop_n   = !(move && ch_zero[act_idx]);

  // R6: at most one acknowledge low
  p_one_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n));

  // R5: an I/O read never pairs with a memory read
  p_strobe_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ior_n |-> (memr_n && iow_n));

  // R4: no lower-numbered request was pending when the grant was made
  p_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    move |-> (($past(eff_req) & ((NCH'(1) << act_idx) - NCH'(1))) == '0));

  // R8: end of process only inside a transfer cycle
  p_eop_in_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !eop_n |-> (dack_n != '1));
endmodule

// File: tb/test_flyby_dma4.sv
module test_flyby_dma4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_chan = '0;
  logic [1:0]  cfg_sel = '0;
  logic        cfg_hi = 1'b0;
  logic [7:0]  cfg_data = '0;
  logic [3:0]  dreq = '0;
  logic        hlda = 1'b0;
  logic        hold_off = 1'b0;
  logic        hrq;
  logic [3:0]  dack_n;
  logic [15:0] addr;
  logic        memr_n, memw_n, ior_n, iow_n, eop_n;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  always #4 clk = ~clk;  // 125 MHz

  flyby_dma4 i_flyby_dma4 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_sel(cfg_sel), .cfg_hi(cfg_hi), .cfg_data(cfg_data), .dreq(dreq),
    .hlda(hlda), .hrq(hrq), .dack_n(dack_n), .addr(addr), .memr_n(memr_n),
    .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n), .eop_n(eop_n)
  );

  // processor model: acknowledge follows request one edge later
  always @(posedge clk) begin
    if (!rst_n) hlda <= 1'b0;
    else        hlda <= hrq && !hold_off;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nerr++;
      $display("FAIL watchdog expired act=%0d exp<=20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  ch;
    logic [15:0] adr;
    logic        dir;
    logic        eop;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{4'b0100, 2'd2, 16'hFFFF, 1'b0, 1'b0},
    '{4'b0100, 2'd2, 16'h0000, 1'b0, 1'b0},
    '{4'b1010, 2'd1, 16'h20FF, 1'b1, 1'b0},
    '{4'b0001, 2'd0, 16'h1000, 1'b0, 1'b0},
    '{4'b0000, 2'd3, 16'h0300, 1'b1, 1'b0},
    '{4'b0001, 2'd0, 16'h1001, 1'b0, 1'b0},
    '{4'b0001, 2'd0, 16'h1002, 1'b0, 1'b1},
    '{4'b1000, 2'd3, 16'h0301, 1'b1, 1'b1},
    '{4'b0010, 2'd1, 16'h2100, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int ch, input logic [1:0] sel, input logic hi, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_sel = sel; cfg_hi = hi; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // waits for the transfer cycle, checks it, then the bus release
  task automatic do_xfer(input int ch, input logic [15:0] a, input logic dir, input logic eop);
    bit got = 0;
    for (int k = 0; k < 40 && !got; k++) begin
      @(negedge clk);
      if (dack_n != 4'hF) got = 1;
    end
    if (!got) begin
      nchk++; nerr++;
      $display("FAIL R6 no transfer act=dack %h exp=channel %0d", dack_n, ch);
    end else begin
      check("R4/R6 dack", 32'(dack_n), 32'(~(4'b0001 << ch) & 4'hF));
      check("R6/R7 addr", 32'(addr), 32'(a));
      check("R5 strobes", 32'({memr_n, memw_n, ior_n, iow_n}), dir ? 32'h6 : 32'h9);
      check("R8 eop", 32'(eop_n), 32'(!eop));
      @(negedge clk);
      check("R9 hrq released", 32'(hrq), 32'd0);
    end
    dreq[ch] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hrq", 32'(hrq), 0);
    check("R1 dack_n", 32'(dack_n), 32'hF);
    check("R1 strobes/eop", 32'({memr_n, memw_n, ior_n, iow_n, eop_n}), 32'h1F);
    check("R1 addr", 32'(addr), 0);
    rst_n = 1'b1;
    // R1/R2: channels masked out of reset, requests ignored
    dreq = 4'hF;
    repeat (10) @(negedge clk);
    check("R2 masked no hrq", 32'(hrq), 0);
    dreq = 4'h0;
    // R10 programming
    cfg_write(0, 2'd0, 0, 8'h00); cfg_write(0, 2'd0, 1, 8'h10);
    cfg_write(0, 2'd1, 0, 8'h02); cfg_write(0, 2'd1, 1, 8'h00);
    cfg_write(1, 2'd0, 0, 8'hFF); cfg_write(1, 2'd0, 1, 8'h20);
    cfg_write(1, 2'd1, 0, 8'h00); cfg_write(1, 2'd1, 1, 8'h01);
    cfg_write(2, 2'd0, 0, 8'hFF); cfg_write(2, 2'd0, 1, 8'hFF);
    cfg_write(2, 2'd1, 0, 8'h05); cfg_write(2, 2'd1, 1, 8'h00);
    cfg_write(3, 2'd0, 0, 8'h00); cfg_write(3, 2'd0, 1, 8'h03);
    cfg_write(3, 2'd1, 0, 8'h01); cfg_write(3, 2'd1, 1, 8'h00);
    cfg_write(0, 2'd2, 0, 8'h00); cfg_write(1, 2'd2, 0, 8'h01);
    cfg_write(2, 2'd2, 0, 8'h00); cfg_write(3, 2'd2, 0, 8'h01);

    // table walk: R4 priority, R5 direction, R7 wrap, R8 terminal count
    for (int v = 0; v < NV; v++) begin
      dreq = dreq | VEC[v].req;
      do_xfer(int'(VEC[v].ch), VEC[v].adr, VEC[v].dir, VEC[v].eop);
    end

    // R3: hold acknowledge withheld
    repeat (6) @(negedge clk);
    hold_off = 1'b1;
    dreq[1] = 1'b1;
    repeat (10) @(negedge clk);
    check("R3 hrq pending", 32'(hrq), 1);
    check("R3 no dack", 32'(dack_n), 32'hF);
    check("R3 no strobes", 32'({memr_n, memw_n, ior_n, iow_n}), 32'hF);
    hold_off = 1'b0;
    do_xfer(1, 16'h2101, 1'b1, 1'b0);

    // R2: hrq one edge after request in idle
    repeat (6) @(negedge clk);
    dreq[1] = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2 hrq timing", 32'(hrq), 1);
    do_xfer(1, 16'h2102, 1'b1, 1'b0);

    // R8: channel 0 masked itself at end of process
    repeat (6) @(negedge clk);
    dreq[0] = 1'b1;
    repeat (12) @(negedge clk);
    check("R8 auto-mask", 32'(hrq), 0);
    check("R8 auto-mask dack", 32'(dack_n), 32'hF);

    // R10: byte writes, count 0 gives immediate end of process
    cfg_write(0, 2'd0, 1, 8'hAB); cfg_write(0, 2'd0, 0, 8'hCD);
    cfg_write(0, 2'd1, 0, 8'h00); cfg_write(0, 2'd1, 1, 8'h00);
    cfg_write(0, 2'd2, 0, 8'h01);
    do_xfer(0, 16'hABCD, 1'b1, 1'b1);

    // R8: count wrapped to FFFF, so no end of process next time
    repeat (6) @(negedge clk);
    cfg_write(0, 2'd2, 0, 8'h00);
    dreq[0] = 1'b1;
    do_xfer(0, 16'hABCE, 1'b0, 1'b0);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule